// File: doc/BRIEF.md
# Variable-Length Instruction Byte Queue

This block is the fetch buffer in front of an instruction decoder for a core whose instructions are one, two or three bytes long. It fills from aligned 32-bit instruction-memory words and shows the decoder a three-byte window that starts at the current program counter. The opcode and both possible operand bytes are therefore visible in the same cycle. The decoder returns the length of the instruction it sees, and the queue consumes exactly that many bytes on the next clock edge. The program counter advances by the same amount.

When the instruction in the window is a taken branch, the queue computes the target from the address after the branch and a signed 8-bit displacement. It then empties its storage and fetches the aligned word that holds the target. The bytes in that word that come before the target are thrown away. A word already in flight when the redirect happens comes back as a stale word, and the queue drops it.

Top module: `fetch_byte_queue`

## Requirements
- R1: Out of reset, `winPc` equals `RESET_PC`, `winValid` is low, and the first request goes out at once for the word at `RESET_PC` with its two low bits cleared.
- R2: `winBytes[7:0]` holds the byte at `winPc`, `[15:8]` the byte at `winPc+1` and `[23:16]` the byte at `winPc+2`. All of the first `decLen` bytes are correct in the same cycle.
- R3: `winValid` is high only while the stored byte count is at least `decLen`. While it is low, `decTake` has no effect: `winPc` and the window do not move.
- R4: When `decTake` and `winValid` are both high and `brTaken` is low, the next cycle shows `winPc` advanced by `decLen` and the window holding the bytes that follow.
- R5: Fetches use `memAddr` with bits [1:0] equal to zero and go to consecutive words. A fetch is issued only when no fetch is outstanding and at least four of the eight byte slots are free. In the returned word, the byte at word address + i sits in `memData[8i+7:8i]`.
- R6: A consumed instruction with `brTaken` high moves `winPc` to (`winPc` + `decLen` + sign-extended `brDisp`) and empties the queue. The next fetch then reads the target's word.
- R7: In the first word accepted after a redirect or reset, the leading bytes given by target[1:0] (0 to 3 of them) are discarded. The window then opens on the target byte.
- R8: `winValid` stays low in the cycle in which the target's word is delivered and can first rise in the cycle after it.
- R9: A word that returns for a fetch issued before a redirect is dropped. No new fetch is issued until that stale word has returned.
- R10: The queue never holds more than eight bytes. With no consumption, the fetches stop once too few slots are free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| memReq | output | 1 | One-cycle word fetch request |
| memAddr | output | ADDR_W | Aligned word address of the request |
| memValid | input | 1 | Returned word is present this cycle |
| memData | input | 32 | Returned word, lowest address in the low byte |
| decLen | input | 2 | Length of the instruction in the window, 1 to 3 |
| decTake | input | 1 | Decoder consumes the instruction in the window |
| brTaken | input | 1 | The consumed instruction is a taken branch |
| brDisp | input | 8 | Signed branch displacement |
| winValid | output | 1 | At least `decLen` bytes are present |
| winPc | output | ADDR_W | Address of the first window byte |
| winBytes | output | 24 | Opcode and two following bytes |

## Verification
The assertions assume three things about the inputs:
- `decLen` lies between 1 and 3 whenever `decTake` is high.
- The memory returns exactly one word per request, in order, at least one cycle after the request.
- `memValid` never rises without a fetch outstanding.

The bench's memory model keeps a single outstanding request with a programmable latency and answers it only after the count expires. The decoder driver uses only lengths 1 to 3 and raises `brTaken` only together with `decTake`.

// File: rtl/fbq_pkg.sv
package fbq_pkg;
  parameter int QBYTES     = 8;
  parameter int WORD_BYTES = 4;
  parameter int WIN_BYTES  = 3;
  parameter int LEN_W      = 2;
  parameter int DISP_W     = 8;

  localparam int PTR_W = $clog2(QBYTES);
  localparam int CNT_W = $clog2(QBYTES + 1);

  typedef struct packed {
    logic             wrEn;
    logic [PTR_W-1:0] wrBase;
    logic [PTR_W-1:0] rdBase;
  } fbqStrobes_t;
endpackage

// File: rtl/fbq_datapath.sv
module fbq_datapath
  import fbq_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  fbqStrobes_t               ctl,
  input  logic [WORD_BYTES*8-1:0]   memData,
  output logic [WIN_BYTES*8-1:0]    winBytes
);
  localparam int LANE_W = $clog2(WORD_BYTES);

  logic [QBYTES*8-1:0] slotsFlat;

  // one byte register per slot; a slot takes the lane that lands on it
  for (genvar s = 0; s < QBYTES; s++) begin : g_slot
    logic [PTR_W-1:0] lane;
    logic [7:0]       q;
    assign lane = PTR_W'(s) - ctl.wrBase;
    always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else if (ctl.wrEn && (lane < PTR_W'(WORD_BYTES)))
        q <= memData[{lane[LANE_W-1:0], 3'b000} +: 8];
    end
    assign slotsFlat[8*s +: 8] = q;
  end

  // window: consecutive slots starting at the read pointer, wrapping
  for (genvar b = 0; b < WIN_BYTES; b++) begin : g_win
    logic [PTR_W-1:0] idx;
    assign idx = ctl.rdBase + PTR_W'(b);
    assign winBytes[8*b +: 8] = slotsFlat[{idx, 3'b000} +: 8];
  end
endmodule

// File: rtl/fbq_ctrl.sv
module fbq_ctrl
  import fbq_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              memValid,
  input  logic [LEN_W-1:0]  decLen,
  input  logic              decTake,
  input  logic              brTaken,
  input  logic [DISP_W-1:0] brDisp,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  output logic              winValid,
  output logic [ADDR_W-1:0] winPc,
  output fbqStrobes_t       ctl
);
  localparam int SKIP_W = $clog2(WORD_BYTES);
  localparam logic [CNT_W-1:0] CAP      = CNT_W'(QBYTES);
  localparam logic [CNT_W-1:0] ROOM_MAX = CNT_W'(QBYTES - WORD_BYTES);
  localparam logic [CNT_W-1:0] WORD_CNT = CNT_W'(WORD_BYTES);

  logic [PTR_W-1:0]  rdPtr;
  logic [CNT_W-1:0]  count;
  logic              pending, stale, alignPend;
  logic [SKIP_W-1:0] alignSkip;
  logic [ADDR_W-1:0] pc, fetchAddr;

  logic [CNT_W-1:0]  lenCnt, popCnt, addCnt;
  logic [SKIP_W-1:0] skipNow;
  logic              pop, redirect, accept, room;
  logic [ADDR_W-1:0] target, dispExt;

  always_comb begin
    lenCnt   = CNT_W'(decLen);
    winValid = (decLen != '0) && (count >= lenCnt);
    pop      = decTake && winValid;
    redirect = pop && brTaken;
    dispExt  = {{(ADDR_W-DISP_W){brDisp[DISP_W-1]}}, brDisp};
    target   = pc + ADDR_W'(decLen) + dispExt;
    room     = count <= ROOM_MAX;
    memReq   = !pending && room && !redirect;
    accept   = memValid && !stale && !redirect;
    skipNow  = alignPend ? alignSkip : '0;
    popCnt   = pop ? lenCnt : '0;
    addCnt   = accept ? (WORD_CNT - CNT_W'(skipNow)) : '0;
    memAddr  = fetchAddr;
    winPc    = pc;
    ctl.wrEn   = accept;
    ctl.wrBase = rdPtr + count[PTR_W-1:0];
    ctl.rdBase = rdPtr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdPtr     <= '0;
      count     <= '0;
      pending   <= 1'b0;
      stale     <= 1'b0;
      alignPend <= 1'b1;
      alignSkip <= RESET_PC[SKIP_W-1:0];
      pc        <= RESET_PC;
      fetchAddr <= {RESET_PC[ADDR_W-1:SKIP_W], {SKIP_W{1'b0}}};
    end else if (redirect) begin
      count     <= '0;
      alignPend <= 1'b1;
      alignSkip <= target[SKIP_W-1:0];
      pc        <= target;
      fetchAddr <= {target[ADDR_W-1:SKIP_W], {SKIP_W{1'b0}}};
      pending   <= pending && !memValid;
      stale     <= pending && !memValid;
    end else begin
      pc    <= pc + (pop ? ADDR_W'(decLen) : '0);
      rdPtr <= rdPtr + PTR_W'(popCnt) + PTR_W'(skipNow * accept);
      count <= count - popCnt + addCnt;
      if (accept) alignPend <= 1'b0;
      if (memReq) fetchAddr <= fetchAddr + ADDR_W'(WORD_BYTES);
      if (memValid) begin
        pending <= 1'b0;
        stale   <= 1'b0;
      end else if (memReq) begin
        pending <= 1'b1;
      end
    end
  end

  AST_CAPACITY: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CAP);                                                   // R10
  AST_FETCH_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    memReq |-> (memAddr[SKIP_W-1:0] == '0));                        // R5
  AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    memReq |=> !memReq);                                            // R5
  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (decTake && winValid && !brTaken) |=> (winPc == $past(winPc) + ADDR_W'($past(decLen)))); // R4
  AST_HOLD_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    !winValid |=> $stable(winPc));                                  // R3
  AST_REDIRECT_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (decTake && winValid && brTaken) |=> (winPc == $past(winPc) + ADDR_W'($past(decLen))
      + {{(ADDR_W-DISP_W){$past(brDisp[DISP_W-1])}}, $past(brDisp)})); // R6
  AST_REDIRECT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (decTake && winValid && brTaken) |=> !winValid);                // R8
  AST_STALE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (memValid && stale) |-> !ctl.wrEn);                             // R9
endmodule

// File: rtl/fetch_byte_queue.sv
module fetch_byte_queue
  import fbq_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] RESET_PC = 16'h0102
) (
  input  logic                    clk,
  input  logic                    rst_n,
  output logic                    memReq,
  output logic [ADDR_W-1:0]       memAddr,
  input  logic                    memValid,
  input  logic [WORD_BYTES*8-1:0] memData,
  input  logic [LEN_W-1:0]        decLen,
  input  logic                    decTake,
  input  logic                    brTaken,
  input  logic [DISP_W-1:0]       brDisp,
  output logic                    winValid,
  output logic [ADDR_W-1:0]       winPc,
  output logic [WIN_BYTES*8-1:0]  winBytes
);
  fbqStrobes_t ctl;

  fbq_ctrl #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .memValid(memValid), .decLen(decLen),
    .decTake(decTake), .brTaken(brTaken), .brDisp(brDisp),
    .memReq(memReq), .memAddr(memAddr), .winValid(winValid),
    .winPc(winPc), .ctl(ctl)
  );

  fbq_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .memData(memData), .winBytes(winBytes)
  );
endmodule

// File: tb/fetch_byte_queue_tb.sv
module fetch_byte_queue_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        memReq, memValid = 1'b0;
  logic [15:0] memAddr;
  logic [31:0] memData = '0;
  logic [1:0]  decLen = 2'd1;
  logic        decTake = 1'b0, brTaken = 1'b0;
  logic [7:0]  brDisp = '0;
  logic        winValid;
  logic [15:0] winPc;
  logic [23:0] winBytes;

  int checks = 0, fails = 0, cyc = 0;
  int memLat = 1, cnt = 0, reqCount = 0, staleCases = 0;
  bit outstanding = 0;
  logic [15:0] respAddr = '0, expFetch = 16'h0100, expPc = 16'h0102;
  int pcQ[$];
  int lenQ[$];

  always #10 clk = ~clk;

  fetch_byte_queue u_dut (
    .clk(clk), .rst_n(rst_n), .memReq(memReq), .memAddr(memAddr),
    .memValid(memValid), .memData(memData), .decLen(decLen),
    .decTake(decTake), .brTaken(brTaken), .brDisp(brDisp),
    .winValid(winValid), .winPc(winPc), .winBytes(winBytes)
  );

  function automatic logic [7:0] memByte(input logic [15:0] a);
    return (a[7:0] * 8'd29) ^ a[15:8] ^ 8'h5A;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // memory model: one outstanding fetch, programmable latency
  always @(negedge clk) begin
    #3;
    if (rst_n) begin
      memValid = 1'b0;
      if (outstanding) begin
        cnt--;
        if (cnt == 0) begin
          memValid = 1'b1;
          memData = {memByte(respAddr + 16'd3), memByte(respAddr + 16'd2),
                     memByte(respAddr + 16'd1), memByte(respAddr)};
          outstanding = 0;
        end
      end
      if (memReq) begin
        reqCount++;
        check(memAddr == expFetch, "R5", "fetch address", memAddr, expFetch);
        check(!outstanding, "R9", "request while outstanding", 1, 0);
        respAddr = memAddr;
        outstanding = 1;
        cnt = memLat;
        expFetch = expFetch + 16'd4;
      end
    end
  end

  // scoreboard monitor: compare each consumed instruction
  always @(negedge clk) begin
    #2;
    if (rst_n && decTake && winValid) begin
      if (pcQ.size() == 0) check(0, "R4", "unexpected pop", winPc, 0);
      else begin
        int p, l;
        p = pcQ.pop_front();
        l = lenQ.pop_front();
        check(winPc == 16'(p), "R4 R6", "window pc", winPc, p);
        for (int i = 0; i < l; i++)
          check(winBytes[8*i +: 8] == memByte(16'(p + i)), "R2 R7", "window byte",
                winBytes[8*i +: 8], memByte(16'(p + i)));
      end
    end
  end

  task automatic issue(input int len, input bit br, input logic [7:0] disp);
    @(negedge clk);
    decLen = 2'(len); decTake = 1'b1; brTaken = br; brDisp = disp;
    pcQ.push_back(int'(expPc));
    lenQ.push_back(len);
    #1;
    while (!winValid) begin @(negedge clk); #1; end
    if (br && outstanding) staleCases++;
    @(posedge clk); #1;
    if (br) begin
      expPc = expPc + 16'(len) + {{8{disp[7]}}, disp};
      expFetch = {expPc[15:2], 2'b00};
    end else expPc = expPc + 16'(len);
    decTake = 1'b0; brTaken = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected <= 50000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] t;
    logic [7:0]  d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #4;
    check(!winValid, "R1", "valid after reset", winValid, 0);
    check(winPc == 16'h0102, "R1", "pc after reset", winPc, 16'h0102);
    check(memReq && memAddr == 16'h0100, "R1", "first fetch", memAddr, 16'h0100);

    repeat (20) @(negedge clk);
    check(reqCount == 2, "R10", "fetches with no consumption", reqCount, 2);

    issue(1, 0, 0); issue(2, 0, 0); issue(3, 0, 0); issue(2, 0, 0);
    issue(3, 0, 0); issue(1, 0, 0); issue(3, 0, 0); issue(3, 0, 0);
    issue(2, 1, 8'h11);
    issue(1, 0, 0); issue(3, 0, 0); issue(2, 0, 0); issue(1, 0, 0);
    issue(3, 1, 8'hE5);
    issue(2, 0, 0); issue(3, 0, 0); issue(1, 0, 0); issue(2, 0, 0);

    // branch to a target with low bits 3, slow memory
    memLat = 20;
    t = expPc + 16'd2;
    d = 8'h20 | ((8'd3 - t[7:0]) & 8'h03);
    issue(2, 1, d);
    decLen = 2'd1;
    @(negedge clk); #4;
    while (!(memValid && respAddr == {expPc[15:2], 2'b00})) begin
      @(negedge clk); #4;
    end
    check(!winValid, "R8", "valid in delivery cycle", winValid, 0);
    @(negedge clk); #4;
    check(winValid, "R8", "valid after delivery", winValid, 1);
    check(winPc == expPc, "R7", "target pc", winPc, expPc);
    check(winBytes[7:0] == memByte(expPc), "R7", "target opcode",
          winBytes[7:0], memByte(expPc));
    decLen = 2'd2; decTake = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); #4;
      check(!winValid, "R3", "valid with one byte", winValid, 0);
      check(winPc == expPc, "R3", "pc held", winPc, expPc);
    end
    decTake = 1'b0;
    memLat = 1;
    issue(2, 0, 0); issue(1, 0, 0); issue(3, 0, 0);

    // redirects while fetches are in flight
    memLat = 6;
    issue(1, 0, 0); issue(2, 1, 8'h07); issue(2, 1, 8'h31); issue(1, 0, 0);
    issue(3, 0, 0); issue(2, 1, 8'hF3); issue(1, 0, 0); issue(3, 0, 0);
    issue(2, 0, 0);
    check(staleCases > 0, "R9", "redirect with fetch in flight", staleCases, 1);
    check(pcQ.size() == 0, "R4", "scoreboard drained", pcQ.size(), 0);

    repeat (3) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule